// File: doc/BRIEF.md
# SV39 Translation Cache Entry Cell

This block is a single slot of a fully associative address-translation cache for three-level SV39 paging. It keeps one stored translation: an address-space identifier, three 9-bit virtual page number fields, a 1 GiB page flag, a 2 MiB page flag, a valid bit and an opaque page-table-entry payload of parameter width. In every cycle it compares that tag with the lookup address and lookup address-space identifier. Without any clock delay it reports whether the slot matches, which page size the match used, and the payload.

A surrounding cache places one cell per way. All cells share one lookup bus, one flush line and one update bus. Each cell gets its own replace-select line from an outside replacement policy. Superpages match hierarchically: a 1 GiB entry compares only the top page number field, and a 2 MiB entry compares the top two fields. A flush invalidates the entry when the lookup identifier matches the stored one. A flush with identifier zero invalidates the entry whatever it stores.

Top module: `sv39_tlb_entry_cell`

## Requirements
- R1: The lookup address is decoded as vpn0 = bits 20..12, vpn1 = bits 29..21 and vpn2 = bits 38..30. Address bits below 12 and above 38 have no effect on any output.
- R2: A hit needs the entry valid, the stored identifier equal to the lookup identifier, and the stored vpn2 equal to the lookup vpn2.
- R3: An entry with the 1 GiB flag hits when the R2 conditions hold, whatever vpn1 and vpn0 are. On such a hit giga_o is 1 and mega_o is 0.
- R4: An entry with the 2 MiB flag and without the 1 GiB flag also needs vpn1 to match to hit. vpn0 is ignored. On such a hit mega_o is 1.
- R5: An entry with neither flag hits only when vpn2, vpn1 and vpn0 all match. On such a hit both flags are 0.
- R6: When upd_valid_i and upd_sel_i are high and flush_i is low at a clock edge, the cell loads the following and sets valid from the next cycle: vpn2 from upd_vpn_i[26:18], vpn1 from [17:9], vpn0 from [8:0], and the identifier, both flags and the payload. This replaces any older content.
- R7: An update with upd_sel_i low leaves the stored entry unchanged.
- R8: A flush with lookup identifier zero clears valid whatever identifier is stored.
- R9: A flush with a nonzero lookup identifier clears valid only when it equals the stored identifier. Otherwise the entry keeps hitting.
- R10: While flush_i is high, no update is written, even if the flush does not invalidate this entry.
- R11: Synchronous active-high reset clears valid, so hit_o is 0 after reset even for an all-zero lookup.
- R12: On a miss, hit_o, giga_o, mega_o and data_o are all 0. On a hit, data_o equals the stored payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Flush request, qualified by lookup_asid_i |
| lookup_asid_i | input | ASID_W | Lookup address-space identifier; also selects which identifier a flush removes |
| lookup_vaddr_i | input | VADDR_W | Lookup virtual address |
| upd_valid_i | input | 1 | Shared update bus carries a new entry |
| upd_sel_i | input | 1 | Replace select for this cell |
| upd_vpn_i | input | 27 | Virtual page number of the new entry |
| upd_asid_i | input | ASID_W | Identifier of the new entry |
| upd_giga_i | input | 1 | New entry is a 1 GiB page |
| upd_mega_i | input | 1 | New entry is a 2 MiB page |
| upd_data_i | input | DATA_W | Payload of the new entry |
| hit_o | output | 1 | Lookup matches this entry |
| giga_o | output | 1 | Hit through a 1 GiB entry |
| mega_o | output | 1 | Hit through a 2 MiB entry |
| data_o | output | DATA_W | Stored payload on a hit, zero otherwise |

## Verification
The hardest case to reach from the ports is a flush and an update in the same cycle where the flush identifier differs from the stored one. The flush then invalidates nothing, so the only visible effect is that the update is lost. The bench loads an entry and issues a flush for another identifier together with a selected update. It then shows that the old translation still hits and the offered one misses. The sweep of page kinds, identifiers and single-field mismatches builds every lookup from the write encoding, so a swapped field or a wrong page-size branch appears as a wrong hit.

// File: rtl/sv39_cell_pkg.sv
package sv39_cell_pkg;

    localparam int VPN_W     = 9;
    localparam int LEVELS    = 3;
    localparam int PAGE_OFS  = 12;
    localparam int UPD_VPN_W = VPN_W * LEVELS;
    localparam int XLAT_TOP  = PAGE_OFS + UPD_VPN_W;

    typedef logic [VPN_W-1:0] vpn_field_t;
    typedef vpn_field_t [LEVELS-1:0] vpn_set_t;

    typedef struct packed {
        vpn_set_t vpn;
        logic     giga;
        logic     mega;
    } page_tag_t;

    function automatic vpn_set_t split_vaddr(input logic [XLAT_TOP-1:0] va);
        vpn_set_t r;
        for (int l = 0; l < LEVELS; l++) begin
            r[l] = va[PAGE_OFS + l*VPN_W +: VPN_W];
        end
        return r;
    endfunction

    function automatic vpn_set_t split_upd_vpn(input logic [UPD_VPN_W-1:0] v);
        vpn_set_t r;
        for (int l = 0; l < LEVELS; l++) begin
            r[l] = v[l*VPN_W +: VPN_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/sv39_cell_tag_store.sv
module sv39_cell_tag_store
    import sv39_cell_pkg::*;
#(
    parameter int ASID_W = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_i,
    input  logic [ASID_W-1:0] flush_asid_i,
    input  logic              wr_en_i,
    input  page_tag_t         wr_tag_i,
    input  logic [ASID_W-1:0] wr_asid_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              valid_o,
    output page_tag_t         tag_o,
    output logic [ASID_W-1:0] asid_o,
    output logic [DATA_W-1:0] data_o
);

    logic              valid_q;
    page_tag_t         tag_q;
    logic [ASID_W-1:0] asid_q;
    logic [DATA_W-1:0] data_q;
    logic              kill;

    // identifier zero removes everything, otherwise only an exact match
    assign kill = (flush_asid_i == '0) || (flush_asid_i == asid_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            asid_q  <= '0;
            data_q  <= '0;
        end else if (flush_i) begin
            if (kill) begin
                valid_q <= 1'b0;
            end
        end else if (wr_en_i) begin
            valid_q <= 1'b1;
            tag_q   <= wr_tag_i;
            asid_q  <= wr_asid_i;
            data_q  <= wr_data_i;
        end
    end

    assign valid_o = valid_q;
    assign tag_o   = tag_q;
    assign asid_o  = asid_q;
    assign data_o  = data_q;

endmodule

// File: rtl/sv39_cell_level_cmp.sv
module sv39_cell_level_cmp
    import sv39_cell_pkg::*;
(
    input  vpn_set_t          stored_i,
    input  vpn_set_t          lookup_i,
    output logic [LEVELS-1:0] eq_o
);

    for (genvar l = 0; l < LEVELS; l++) begin : g_level
        assign eq_o[l] = (stored_i[l] == lookup_i[l]);
    end

endmodule

// File: rtl/sv39_cell_match.sv
module sv39_cell_match
    import sv39_cell_pkg::*;
#(
    parameter int ASID_W = 2
) (
    input  logic              valid_i,
    input  logic [ASID_W-1:0] stored_asid_i,
    input  logic [ASID_W-1:0] lookup_asid_i,
    input  logic [LEVELS-1:0] level_eq_i,
    input  logic              giga_i,
    input  logic              mega_i,
    output logic              hit_o,
    output logic              giga_o,
    output logic              mega_o
);

    logic top_match;
    logic mid_match;

    assign top_match = valid_i && (stored_asid_i == lookup_asid_i) && level_eq_i[2];
    assign mid_match = level_eq_i[1] && (mega_i || level_eq_i[0]);

    always_comb begin
        hit_o  = top_match && (giga_i || mid_match);
        giga_o = hit_o && giga_i;
        mega_o = hit_o && !giga_i && mega_i;
    end

endmodule

// File: rtl/sv39_tlb_entry_cell.sv
module sv39_tlb_entry_cell
    import sv39_cell_pkg::*;
#(
    parameter int ASID_W  = 2,
    parameter int DATA_W  = 16,
    parameter int VADDR_W = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic [ASID_W-1:0]    lookup_asid_i,
    input  logic [VADDR_W-1:0]   lookup_vaddr_i,
    input  logic                 upd_valid_i,
    input  logic                 upd_sel_i,
    input  logic [UPD_VPN_W-1:0] upd_vpn_i,
    input  logic [ASID_W-1:0]    upd_asid_i,
    input  logic                 upd_giga_i,
    input  logic                 upd_mega_i,
    input  logic [DATA_W-1:0]    upd_data_i,
    output logic                 hit_o,
    output logic                 giga_o,
    output logic                 mega_o,
    output logic [DATA_W-1:0]    data_o
);

    logic              entry_valid;
    page_tag_t         stored_tag;
    logic [ASID_W-1:0] stored_asid;
    logic [DATA_W-1:0] stored_data;
    page_tag_t         wr_tag;
    vpn_set_t          lookup_vpn;
    logic [LEVELS-1:0] level_eq;
    logic              wr_en;
    logic              unused_addr_bits;

    assign wr_en             = upd_valid_i && upd_sel_i;
    assign wr_tag.vpn        = split_upd_vpn(upd_vpn_i);
    assign wr_tag.giga       = upd_giga_i;
    assign wr_tag.mega       = upd_mega_i;
    assign lookup_vpn        = split_vaddr(lookup_vaddr_i[XLAT_TOP-1:0]);
    assign unused_addr_bits  = ^{lookup_vaddr_i[VADDR_W-1:XLAT_TOP],
                                 lookup_vaddr_i[PAGE_OFS-1:0]};

    sv39_cell_tag_store #(
        .ASID_W (ASID_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .flush_i      (flush_i),
        .flush_asid_i (lookup_asid_i),
        .wr_en_i      (wr_en),
        .wr_tag_i     (wr_tag),
        .wr_asid_i    (upd_asid_i),
        .wr_data_i    (upd_data_i),
        .valid_o      (entry_valid),
        .tag_o        (stored_tag),
        .asid_o       (stored_asid),
        .data_o       (stored_data)
    );

    sv39_cell_level_cmp u_cmp (
        .stored_i (stored_tag.vpn),
        .lookup_i (lookup_vpn),
        .eq_o     (level_eq)
    );

    sv39_cell_match #(
        .ASID_W (ASID_W)
    ) u_match (
        .valid_i       (entry_valid),
        .stored_asid_i (stored_asid),
        .lookup_asid_i (lookup_asid_i),
        .level_eq_i    (level_eq),
        .giga_i        (stored_tag.giga),
        .mega_i        (stored_tag.mega),
        .hit_o         (hit_o),
        .giga_o        (giga_o),
        .mega_o        (mega_o)
    );

    assign data_o = hit_o ? stored_data : '0;

endmodule

// File: rtl/sv39_cell_checker.sv
module sv39_cell_checker
    import sv39_cell_pkg::*;
#(
    parameter int ASID_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_i,
    input logic [ASID_W-1:0] lookup_asid_i,
    input logic              upd_valid_i,
    input logic              upd_sel_i,
    input logic [ASID_W-1:0] upd_asid_i,
    input logic              hit_o,
    input logic              giga_o,
    input logic              mega_o,
    input logic              entry_valid,
    input page_tag_t         stored_tag,
    input logic [ASID_W-1:0] stored_asid
);

    p_invalid_misses_r2: assert property (@(posedge clk) disable iff (rst)
        !entry_valid |-> !hit_o);

    p_flags_need_hit_r12: assert property (@(posedge clk) disable iff (rst)
        (giga_o || mega_o) |-> (hit_o && !(giga_o && mega_o)));

    p_giga_hit_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (hit_o && stored_tag.giga) |-> (giga_o && !mega_o));

    p_update_loads_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid_i && upd_sel_i && !flush_i) |=> (entry_valid && stored_asid == $past(upd_asid_i)));

    p_unselected_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (!flush_i && !(upd_valid_i && upd_sel_i)) |=>
            ($stable(entry_valid) && $stable(stored_tag) && $stable(stored_asid)));

    p_global_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (flush_i && lookup_asid_i == '0) |=> !entry_valid);

    p_flush_match_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_i && lookup_asid_i == stored_asid) |=> !entry_valid);

    p_flush_blocks_write_r10: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> ($stable(stored_tag) && $stable(stored_asid)));

    p_reset_clears_r11: assert property (@(posedge clk)
        $past(rst) |-> !entry_valid);

endmodule

bind sv39_tlb_entry_cell sv39_cell_checker #(
    .ASID_W (ASID_W)
) u_checker (
    .clk           (clk),
    .rst           (rst),
    .flush_i       (flush_i),
    .lookup_asid_i (lookup_asid_i),
    .upd_valid_i   (upd_valid_i),
    .upd_sel_i     (upd_sel_i),
    .upd_asid_i    (upd_asid_i),
    .hit_o         (hit_o),
    .giga_o        (giga_o),
    .mega_o        (mega_o),
    .entry_valid   (entry_valid),
    .stored_tag    (stored_tag),
    .stored_asid   (stored_asid)
);

// File: tb/sv39_tlb_entry_cell_test.sv
module sv39_tlb_entry_cell_test;

    localparam int AW = 2;
    localparam int DW = 16;
    localparam int VW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush_i = 1'b0;
    logic [AW-1:0] lookup_asid_i = '0;
    logic [VW-1:0] lookup_vaddr_i = '0;
    logic          upd_valid_i = 1'b0;
    logic          upd_sel_i = 1'b0;
    logic [26:0]   upd_vpn_i = '0;
    logic [AW-1:0] upd_asid_i = '0;
    logic          upd_giga_i = 1'b0;
    logic          upd_mega_i = 1'b0;
    logic [DW-1:0] upd_data_i = '0;
    logic          hit_o, giga_o, mega_o;
    logic [DW-1:0] data_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model of the stored entry
    bit          m_valid = 1'b0;
    bit [AW-1:0] m_asid = '0;
    bit [26:0]   m_vpn = '0;
    bit          m_g = 1'b0;
    bit          m_m = 1'b0;
    bit [DW-1:0] m_data = '0;

    always #10 clk = ~clk;

    sv39_tlb_entry_cell #(.ASID_W(AW), .DATA_W(DW), .VADDR_W(VW)) uut (
        .clk(clk), .rst(rst), .flush_i(flush_i),
        .lookup_asid_i(lookup_asid_i), .lookup_vaddr_i(lookup_vaddr_i),
        .upd_valid_i(upd_valid_i), .upd_sel_i(upd_sel_i), .upd_vpn_i(upd_vpn_i),
        .upd_asid_i(upd_asid_i), .upd_giga_i(upd_giga_i), .upd_mega_i(upd_mega_i),
        .upd_data_i(upd_data_i), .hit_o(hit_o), .giga_o(giga_o), .mega_o(mega_o),
        .data_o(data_o)
    );

    task automatic lookup(input bit [AW-1:0] la, input bit [VW-1:0] va, input string req);
        bit [8:0] v0, v1, v2;
        bit e_hit, e_g, e_m;
        bit [DW-1:0] e_d;
        @(negedge clk);
        lookup_asid_i  = la;
        lookup_vaddr_i = va;
        v0 = va[20:12]; v1 = va[29:21]; v2 = va[38:30];
        e_hit = m_valid && (m_asid == la) && (v2 == m_vpn[26:18]) &&
                (m_g || ((v1 == m_vpn[17:9]) && (m_m || v0 == m_vpn[8:0])));
        e_g = e_hit && m_g;
        e_m = e_hit && !m_g && m_m;
        e_d = e_hit ? m_data : '0;
        #2;
        tests++;
        if ({hit_o, giga_o, mega_o, data_o} !== {e_hit, e_g, e_m, e_d}) begin
            fails++;
            $display("FAIL %s: asid=%0d va=%h got hit=%b g=%b m=%b d=%h exp hit=%b g=%b m=%b d=%h",
                     req, la, va, hit_o, giga_o, mega_o, data_o, e_hit, e_g, e_m, e_d);
        end
    endtask

    task automatic cycle(input bit fl, input bit [AW-1:0] fa, input bit uv, input bit us,
                         input bit [AW-1:0] ua, input bit [26:0] vpn,
                         input bit g, input bit m, input bit [DW-1:0] d);
        @(negedge clk);
        flush_i = fl; lookup_asid_i = fa;
        upd_valid_i = uv; upd_sel_i = us; upd_asid_i = ua; upd_vpn_i = vpn;
        upd_giga_i = g; upd_mega_i = m; upd_data_i = d;
        @(posedge clk);
        if (fl) begin
            if (fa == '0 || fa == m_asid) m_valid = 1'b0;
        end else if (uv && us) begin
            m_valid = 1'b1; m_asid = ua; m_vpn = vpn; m_g = g; m_m = m; m_data = d;
        end
        @(negedge clk);
        flush_i = 1'b0; upd_valid_i = 1'b0; upd_sel_i = 1'b0;
    endtask

    function automatic bit [VW-1:0] addr_of(input bit [26:0] vpn);
        return {25'h0, vpn, 12'h5a5};
    endfunction

    initial begin
        #3_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: an all-zero lookup would match the cleared tag if valid were set
        lookup('0, '0, "R11");

        // sweep page kinds, stored identifiers, lookup identifiers, field mismatches
        for (int kind = 0; kind < 3; kind++) begin
            for (int sa = 0; sa < 4; sa++) begin
                bit [26:0] vpn;
                vpn = {9'(kind*53 + sa*7 + 1), 9'(kind*11 + sa*29 + 3), 9'(sa*61 + kind + 5)};
                cycle(1'b0, '0, 1'b1, 1'b1, AW'(sa), vpn, kind == 2, kind == 1,
                      DW'(kind*4096 + sa*257 + 'h33));
                for (int la = 0; la < 4; la++) begin
                    for (int pm = 0; pm < 16; pm++) begin
                        bit [VW-1:0] va;
                        string req;
                        va = addr_of(vpn);
                        if (pm[0]) va[20] = ~va[20];
                        if (pm[1]) va[21] = ~va[21];
                        if (pm[2]) va[30] = ~va[30];
                        if (pm[3]) begin va[11] = ~va[11]; va[39] = ~va[39]; va[63] = ~va[63]; end
                        if (pm[3])               req = "R1";
                        else if (la != sa || pm[2]) req = "R2";
                        else if (kind == 2)     req = "R3";
                        else if (kind == 1)     req = "R4";
                        else                    req = "R5";
                        lookup(AW'(la), va, req);
                    end
                end
            end
        end

        // R6: overwrite a valid entry with a different one
        cycle(1'b0, '0, 1'b1, 1'b1, 2'd2, 27'h1234567, 1'b0, 1'b0, 16'hbeef);
        lookup(2'd2, addr_of(27'h1234567), "R6");
        lookup(2'd2, addr_of(27'h1234566), "R6");

        // R7: unselected update leaves the entry alone
        cycle(1'b0, '0, 1'b1, 1'b0, 2'd1, 27'h0abcdef, 1'b1, 1'b0, 16'h1111);
        lookup(2'd2, addr_of(27'h1234567), "R7");
        lookup(2'd1, addr_of(27'h0abcdef), "R7");

        // R9: flush of another identifier keeps the entry, own identifier removes it
        cycle(1'b1, 2'd1, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0);
        lookup(2'd2, addr_of(27'h1234567), "R9");
        cycle(1'b1, 2'd2, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0);
        lookup(2'd2, addr_of(27'h1234567), "R9");

        // R8: identifier zero removes an entry stored under identifier 3
        cycle(1'b0, '0, 1'b1, 1'b1, 2'd3, 27'h7654321, 1'b0, 1'b1, 16'h2222);
        lookup(2'd3, addr_of(27'h7654321), "R8");
        cycle(1'b1, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0);
        lookup(2'd3, addr_of(27'h7654321), "R8");

        // R10: flush for another identifier still blocks a selected update
        cycle(1'b0, '0, 1'b1, 1'b1, 2'd1, 27'h0111111, 1'b0, 1'b0, 16'h3333);
        cycle(1'b1, 2'd2, 1'b1, 1'b1, 2'd3, 27'h0222222, 1'b0, 1'b0, 16'h4444);
        lookup(2'd1, addr_of(27'h0111111), "R10");
        lookup(2'd3, addr_of(27'h0222222), "R10");
        cycle(1'b1, 2'd1, 1'b1, 1'b1, 2'd3, 27'h0222222, 1'b0, 1'b0, 16'h4444);
        lookup(2'd1, addr_of(27'h0111111), "R10");
        lookup(2'd3, addr_of(27'h0222222), "R10");

        // R12: miss outputs all zero while entry valid but identifier differs
        cycle(1'b0, '0, 1'b1, 1'b1, 2'd1, 27'h0333333, 1'b1, 1'b1, 16'hffff);
        lookup(2'd2, addr_of(27'h0333333), "R12");
        lookup(2'd1, addr_of(27'h0333333), "R12");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule